// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one byte into an asynchronous serial character each time the host pulses a write strobe. A character is a low start bit, five to eight data bits sent least significant first, an optional parity bit, and a high stop period. Word length, parity and stop length come from a set of line-control inputs. A 16-bit divisor sets the bit rate, and each bit lasts sixteen ticks of the divided clock.

A single holding register sits in front of the shift register. A byte written while a character is being sent waits there and goes out directly after the current stop period, with no idle gap. The line-control fields and the divisor are captured when a byte moves from the holding register into the shift register, so changing them mid-character affects only the next character.

Top module: `uart_char_tx`

## Requirements
- R1: After reset, and whenever no character is in progress, `txd` is 1, `busy` is 0 and, with no pending byte, `hold_empty` is 1.
- R2: A byte written while idle is loaded on the next clock edge. From that edge `busy` is 1 and `txd` is 0 for one bit time (the start bit).
- R3: `word_len` code 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits. They follow the start bit, least significant first, and unused upper bits of the byte are not sent.
- R4: With `par_en`=1 and `par_stick`=0, a parity bit follows the last data bit. With `par_even`=1 it makes the count of ones in data plus parity even. With `par_even`=0 it makes that count odd.
- R5: With `par_en`=1 and `par_stick`=1, the parity bit is constant: 1 when `par_even`=0 and 0 when `par_even`=1.
- R6: With `par_en`=0, no parity bit is sent, and the stop period follows the last data bit directly.
- R7: The stop period is high for 1 bit time when `stop_sel`=0 and 2 bit times when `stop_sel`=1. With `stop_sel`=1 and `word_len`=0 it is 1.5 bit times. `busy` falls exactly at its end.
- R8: One bit time is 16×`divisor` clock cycles, and a `divisor` of 0 behaves as 1.
- R9: A write drives `hold_empty` to 0 on the next edge. The flag returns to 1 on the edge where the byte enters the shift register. A byte written during a character starts its start bit on the edge where the previous stop period ends.
- R10: The line-control inputs and `divisor` are sampled when a byte is loaded. Changing them during a character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| word_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select (stick value inverted) |
| par_stick | input | 1 | Constant parity bit mode |
| stop_sel | input | 1 | Long stop period select |
| divisor | input | 16 | Clock divider for the 16x tick |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Character in progress |
| hold_empty | output | 1 | Holding register free |

## Verification
Each character is sampled mid-bit at every bit position and compared with a frame built in the bench. The frames cover all four word lengths, each parity mode and each stop length, and the divisors 0, 1, 2 and 3. Bytes with ones above the chosen word length show whether masking and parity use only the sent bits. Checking the exact cycle where `busy` falls separates 1, 1.5 and 2 stop bits and a wrong divisor. A second write during a character, and a line-control change during a character, separate a correct hand-over from a lost byte, an idle gap, or fields read live instead of latched.

// File: rtl/uart_char_tx.sv
`timescale 1ns/1ps
module uart_char_tx #(
  parameter int DW = 8,
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      word_len,
  input  logic            par_en,
  input  logic            par_even,
  input  logic            par_stick,
  input  logic            stop_sel,
  input  logic [DIVW-1:0] divisor,
  output logic            txd,
  output logic            busy,
  output logic            hold_empty
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t             state;
  logic [DW-1:0]   hold_q, sh_q;
  logic            hold_full;
  logic [2:0]      last_idx_q, idx_q;
  logic            par_on_q, par_bit_q;
  logic [4:0]      stop_last_q, sub_q;
  logic [DIVW-1:0] div_q, pre_q;

  logic            tick, bit_last, load_now, ones;
  logic [DW-1:0]   mask;
  logic [4:0]      sub_end;

  assign tick     = (pre_q == div_q - 1'b1);
  assign sub_end  = (state == S_STOP) ? stop_last_q : 5'd15;
  assign bit_last = tick && (sub_q == sub_end);
  assign load_now = hold_full && (state == S_IDLE || (state == S_STOP && bit_last));
  assign mask     = 8'hFF >> (2'd3 - word_len);
  assign ones     = ^(hold_q & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      hold_q      <= '0;
      hold_full   <= 1'b0;
      sh_q        <= '0;
      last_idx_q  <= '0;
      idx_q       <= '0;
      par_on_q    <= 1'b0;
      par_bit_q   <= 1'b0;
      stop_last_q <= 5'd15;
      sub_q       <= '0;
      div_q       <= 16'd1;
      pre_q       <= '0;
    end else begin
      if (load_now) begin
        hold_full   <= 1'b0;
        state       <= S_START;
        sh_q        <= hold_q & mask;
        last_idx_q  <= {1'b1, word_len} - 3'd4 + 3'd4;
        idx_q       <= '0;
        par_on_q    <= par_en;
        par_bit_q   <= par_stick ? ~par_even : (par_even ? ones : ~ones);
        stop_last_q <= !stop_sel ? 5'd15 : (word_len == 2'd0 ? 5'd23 : 5'd31);
        div_q       <= (divisor == '0) ? 16'd1 : divisor;
        pre_q       <= '0;
        sub_q       <= '0;
      end else if (state != S_IDLE) begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) sub_q <= bit_last ? '0 : sub_q + 1'b1;
        if (bit_last) begin
          case (state)
            S_START: begin
              state <= S_DATA;
              idx_q <= '0;
            end
            S_DATA: begin
              sh_q <= sh_q >> 1;
              if (idx_q == last_idx_q) state <= par_on_q ? S_PAR : S_STOP;
              else idx_q <= idx_q + 1'b1;
            end
            S_PAR:   state <= S_STOP;
            default: state <= S_IDLE;
          endcase
        end
      end
      if (wr_en) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh_q[0];
      S_PAR:   txd = par_bit_q;
      default: txd = 1'b1;
    endcase
  end

  assign busy       = (state != S_IDLE);
  assign hold_empty = !hold_full;

endmodule

module uart_char_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic txd,
  input logic busy,
  input logic hold_empty
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !txd);
  a_r7_stop_before_idle: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(txd));
  a_r9_write_fills: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !hold_empty);
  a_r9_pending_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hold_empty) |=> (busy && !txd && hold_empty));
endmodule

bind uart_char_tx uart_char_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .txd(txd), .busy(busy), .hold_empty(hold_empty)
);

// File: tb/test_uart_char_tx.sv
`timescale 1ns/1ps
module test_uart_char_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  word_len = 2'd3;
  logic        par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, stop_sel = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic        txd, busy, hold_empty;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  uart_char_tx i_uart_char_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .stop_sel(stop_sel),
    .divisor(divisor), .txd(txd), .busy(busy), .hold_empty(hold_empty)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic adv(int m);
    repeat (m) @(posedge clk);
    #1;
  endtask

  task automatic set_lc(logic [1:0] wl, logic pe, logic ev, logic st, logic ss, logic [15:0] dv);
    word_len = wl; par_en = pe; par_even = ev; par_stick = st; stop_sel = ss; divisor = dv;
  endtask

  // write while idle; ends at load edge + 1 time unit
  task automatic start(logic [7:0] d);
    chk("R1 idle txd", txd, 1'b1);
    @(negedge clk);
    wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    chk("R9 hold_empty after write", hold_empty, 1'b0);
    chk("R2 not yet busy", busy, 1'b0);
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1;
    chk("R9 hold_empty after load", hold_empty, 1'b1);
    chk("R2 start bit", txd, 1'b0);
    chk("R2 busy", busy, 1'b1);
  endtask

  // begins at load edge + 1; ends at end edge + 1
  task automatic check_frame(logic [7:0] d, logic [1:0] wl, logic pe, logic ev, logic st,
                             logic ss, int dv, bit nxt, string tag);
    int n, nb, stop_cyc, total, el, ones;
    logic pbit, e;
    n = int'(wl) + 5;
    nb = 1 + n + int'(pe);
    stop_cyc = ss ? (wl == 2'd0 ? 24 : 32) : 16;
    total = dv * (16 * nb + stop_cyc);
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    pbit = st ? ~ev : (ev ? logic'(ones % 2) : logic'(1 - ones % 2));
    el = 0;
    for (int j = 0; j <= nb; j++) begin
      int tgt;
      tgt = 8 * dv + 16 * dv * j;
      adv(tgt - el);
      el = tgt;
      if (j == 0) begin e = 1'b0; chk("R2 start mid", txd, e); end
      else if (j <= n) begin e = d[j-1]; chk("R3 data bit", txd, e); end
      else if (pe && j == n + 1) begin
        e = pbit;
        if (st) chk("R5 stick parity", txd, e); else chk("R4 parity", txd, e);
      end else begin e = 1'b1; chk("R6 R7 stop after data/parity", txd, e); end
    end
    adv(total - 1 - el);
    chk({tag, " busy before end"}, busy, 1'b1);
    chk({tag, " txd high before end"}, txd, 1'b1);
    adv(1);
    if (nxt) begin
      chk("R9 back-to-back start", txd, 1'b0);
      chk("R9 back-to-back busy", busy, 1'b1);
      chk("R9 hold_empty on reload", hold_empty, 1'b1);
    end else begin
      chk({tag, " busy ends"}, busy, 1'b0);
      chk("R1 idle high", txd, 1'b1);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset hold_empty", hold_empty, 1'b1);
  endtask

  task automatic t_8n1;
    set_lc(2'd3, 0, 0, 0, 0, 16'd1);
    start(8'hA5); check_frame(8'hA5, 2'd3, 0, 0, 0, 0, 1, 0, "R6 R8");
  endtask

  task automatic t_parity;
    set_lc(2'd2, 1, 1, 0, 0, 16'd2);
    start(8'hDB); check_frame(8'hDB, 2'd2, 1, 1, 0, 0, 2, 0, "R4 even");
    set_lc(2'd1, 1, 0, 0, 1, 16'd3);
    start(8'hC7); check_frame(8'hC7, 2'd1, 1, 0, 0, 1, 3, 0, "R7 two stop");
  endtask

  task automatic t_short_stop;
    set_lc(2'd0, 1, 0, 0, 1, 16'd1);
    start(8'hF3); check_frame(8'hF3, 2'd0, 1, 0, 0, 1, 1, 0, "R7 1.5 stop");
    set_lc(2'd0, 0, 0, 0, 0, 16'd2);
    start(8'hEA); check_frame(8'hEA, 2'd0, 0, 0, 0, 0, 2, 0, "R3 five bits");
  endtask

  task automatic t_stick;
    set_lc(2'd3, 1, 0, 1, 0, 16'd1);
    start(8'h00); check_frame(8'h00, 2'd3, 1, 0, 1, 0, 1, 0, "R5 stick one");
    set_lc(2'd3, 1, 1, 1, 0, 16'd1);
    start(8'hFF); check_frame(8'hFF, 2'd3, 1, 1, 1, 0, 1, 0, "R5 stick zero");
  endtask

  task automatic t_div0;
    set_lc(2'd2, 0, 0, 0, 0, 16'd0);
    start(8'h35); check_frame(8'h35, 2'd2, 0, 0, 0, 0, 1, 0, "R8 divisor 0");
  endtask

  task automatic t_b2b;
    set_lc(2'd3, 1, 1, 0, 0, 16'd2);
    start(8'h3C);
    fork
      check_frame(8'h3C, 2'd3, 1, 1, 0, 0, 2, 1, "R9 first");
      begin
        adv(40);
        @(negedge clk); wr_data = 8'h81; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
        chk("R9 pending hold_empty", hold_empty, 1'b0);
        chk("R9 still busy", busy, 1'b1);
      end
    join
    check_frame(8'h81, 2'd3, 1, 1, 0, 0, 2, 0, "R9 second");
  endtask

  task automatic t_latch;
    set_lc(2'd3, 0, 0, 0, 0, 16'd1);
    start(8'hC3);
    fork
      check_frame(8'hC3, 2'd3, 0, 0, 0, 0, 1, 0, "R10 latched");
      begin
        adv(20);
        @(negedge clk);
        set_lc(2'd0, 1, 1, 1, 1, 16'd5);
      end
    join
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset;
    #10 rst_n = 1'b1;
    adv(3);
    t_reset;
    t_8n1;
    t_parity;
    t_short_stop;
    t_stick;
    t_div0;
    t_b2b;
    t_latch;
    adv(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule